// File: doc/BRIEF.md
# Four-Lane Deskew Line Buffer

This block takes four 16-bit camera lanes, each arriving on its own strobe clock, and puts them back into step on one system clock. Cable lengths and source drift shift the lane clocks in phase against one another. Each lane therefore fills a private dual-clock FIFO, and a single read controller in the system domain empties the four FIFOs together. Every output word carries one word from each lane, taken from the same position in its line.

A lane writes only on strobe edges where its line-valid input is high. The read controller starts a burst only once the emptiest FIFO holds at least half its depth. The burst pops all four FIFOs every system cycle until that emptiest lane runs dry. A write to a full FIFO sets a sticky overflow flag. If the burst ends with some lanes empty and others still holding words, the lanes have lost alignment, and a sticky underflow flag is set.

The controller has two states. WAIT_FILL is entered at reset and after every burst. It takes the START transition to STREAM once the emptiest lane's fill level reaches half the FIFO depth. STREAM pops on every cycle in which no lane is empty. When any lane becomes empty it takes the FINISH transition back to WAIT_FILL. FINISH is clean if every lane is empty at that point, and it sets the underflow flag if any lane still holds words.

Top module: `deskew_line_buffer`

## Requirements
- R1: After reset, `word_valid`, `overflow` and `underflow` are all 0.
- R2: No output word appears while any lane's FIFO holds fewer than DEPTH/2 (256) words. Once the emptiest lane reaches 256 words, output words begin to appear.
- R3: Each output word holds one word from each lane, all from the same position in their lines. Lane 0 sits in bits 15:0, lane 1 in 31:16, lane 2 in 47:32 and lane 3 in 63:48, whatever the phase and rate differences between the lane strobes.
- R4: Once a burst starts, words emerge one per system cycle, in write order. The burst runs until the emptiest lane is drained, so a line of equal length on all lanes is delivered in full, and `word_valid` then stays low.
- R5: A write attempt (line-valid high on a strobe edge) to a lane whose FIFO is full sets `overflow`. The flag stays set until reset.
- R6: When a burst ends with at least one lane empty and at least one lane still holding words, `underflow` is set and stays set until reset. A burst that ends with all lanes empty leaves `underflow` unchanged.
- R7: Reset clears both sticky flags and empties all FIFOs.
- R8: Strobe edges with line-valid low write nothing. Data present on such edges never appears in the output.
- R9: Each FIFO accepts 512 words without overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | Common read-side system clock |
| rst_n | input | 1 | Asynchronous active-low reset for all domains |
| lane_clk | input | NCH (4) | Per-lane strobe, the write clock of that lane's FIFO |
| lane_valid | input | NCH (4) | Per-lane line-valid, the write enable |
| lane_data | input | NCH*DW (64) | Lane i data in bits 16i+15:16i |
| word_data | output | NCH*DW (64) | Merged output word, lane 0 in the low bits |
| word_valid | output | 1 | High for one cycle per merged word |
| overflow | output | 1 | Sticky: a write hit a full FIFO |
| underflow | output | 1 | Sticky: a burst ended with the lanes misaligned |

## Verification
The assertions assume three things about the inputs. Lane strobes are free-running and never stop between the edges that carry a line. Line-valid and data change only away from the rising strobe edge. Within a normal line, every lane writes no slower than the system clock reads, so the emptiest lane cannot run dry in the middle of a line. The stimulus keeps to these limits as follows. Every strobe period is shorter than the 8 ns system period, and the lane with gapped writes pauses only once every eight words. Misaligned lines and overfilled lanes are driven on purpose, only to exercise the two error flags.

// File: rtl/dlb_pkg.sv
`timescale 1ns/1ps
package dlb_pkg;
    typedef enum logic {
        RD_WAIT_FILL = 1'b0,
        RD_STREAM    = 1'b1
    } rd_state_e;
endpackage

// File: rtl/dlb_gray_cdc.sv
`timescale 1ns/1ps
// Two-flop synchroniser for a Gray-coded pointer; output decoded to binary.
module dlb_gray_cdc #(
    parameter int PW = 10
) (
    input  logic          dst_clk,
    input  logic          rst_n,
    input  logic [PW-1:0] src_gray,
    output logic [PW-1:0] dst_bin
);
    logic [PW-1:0] meta_q;
    logic [PW-1:0] stable_q;

    always_ff @(posedge dst_clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q   <= '0;
            stable_q <= '0;
        end else begin
            meta_q   <= src_gray;
            stable_q <= meta_q;
        end
    end

    for (genvar i = 0; i < PW; i++) begin : g_dec
        assign dst_bin[i] = ^stable_q[PW-1:i];
    end
endmodule

// File: rtl/dlb_lane_fifo.sv
`timescale 1ns/1ps
// Dual-clock FIFO for one lane, with Gray pointers and sticky overflow.
module dlb_lane_fifo #(
    parameter int DW    = 16,
    parameter int DEPTH = 512
) (
    input  logic                       wr_clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [DW-1:0]              wr_data,
    input  logic                       rd_clk,
    input  logic                       rd_pop,
    output logic [DW-1:0]              rd_data,
    output logic [$clog2(DEPTH):0]     rd_level,
    output logic                       ovf_rd
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;
    localparam logic [PW-1:0] FULL_LVL = PW'(DEPTH);

    logic [DW-1:0] mem [DEPTH];

    logic [PW-1:0] wbin, wgray, wbin_nx;
    logic [PW-1:0] rbin, rgray, rbin_nx;
    logic [PW-1:0] rbin_w, wbin_r;
    logic [PW-1:0] wr_level;
    logic          full, ovf_w;

    // write side
    assign wr_level = wbin - rbin_w;
    assign full     = (wr_level == FULL_LVL);
    assign wbin_nx  = wbin + 1'b1;

    always_ff @(posedge wr_clk or negedge rst_n) begin
        if (!rst_n) begin
            wbin  <= '0;
            wgray <= '0;
            ovf_w <= 1'b0;
        end else if (wr_en) begin
            if (full) begin
                ovf_w <= 1'b1;
            end else begin
                wbin  <= wbin_nx;
                wgray <= wbin_nx ^ (wbin_nx >> 1);
            end
        end
    end

    always_ff @(posedge wr_clk) begin
        if (wr_en && !full) begin
            mem[wbin[AW-1:0]] <= wr_data;
        end
    end

    // read side
    assign rbin_nx  = rbin + 1'b1;
    assign rd_level = wbin_r - rbin;
    assign rd_data  = mem[rbin[AW-1:0]];

    always_ff @(posedge rd_clk or negedge rst_n) begin
        if (!rst_n) begin
            rbin  <= '0;
            rgray <= '0;
        end else if (rd_pop) begin
            rbin  <= rbin_nx;
            rgray <= rbin_nx ^ (rbin_nx >> 1);
        end
    end

    dlb_gray_cdc #(.PW(PW)) u_wptr_sync (
        .dst_clk (rd_clk),
        .rst_n   (rst_n),
        .src_gray(wgray),
        .dst_bin (wbin_r)
    );

    dlb_gray_cdc #(.PW(PW)) u_rptr_sync (
        .dst_clk (wr_clk),
        .rst_n   (rst_n),
        .src_gray(rgray),
        .dst_bin (rbin_w)
    );

    dlb_gray_cdc #(.PW(1)) u_ovf_sync (
        .dst_clk (rd_clk),
        .rst_n   (rst_n),
        .src_gray(ovf_w),
        .dst_bin (ovf_rd)
    );

    assert_level_bound_R9: assert property (@(posedge wr_clk) disable iff (!rst_n)
        wr_level <= FULL_LVL);

    assert_no_pop_empty_R6: assert property (@(posedge rd_clk) disable iff (!rst_n)
        rd_pop |-> (rd_level != '0));

    assert_ovf_hold_R5: assert property (@(posedge wr_clk) disable iff (!rst_n)
        ovf_w |=> ovf_w);
endmodule

// File: rtl/dlb_read_ctrl.sv
`timescale 1ns/1ps
// System-domain burst controller: start at half fill, drain to slowest-lane empty.
module dlb_read_ctrl
    import dlb_pkg::*;
#(
    parameter int NCH  = 4,
    parameter int PW   = 10,
    parameter int HALF = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH*PW-1:0] levels,
    output logic              pop,
    output logic              unf
);
    localparam logic [PW-1:0] HALF_LVL = PW'(HALF);

    rd_state_e     state, nxt;
    logic [PW-1:0] min_lvl;
    logic          any_empty, all_empty, unf_set;

    always_comb begin
        min_lvl   = levels[PW-1:0];
        any_empty = 1'b0;
        all_empty = 1'b1;
        for (int i = 0; i < NCH; i++) begin
            if (levels[i*PW +: PW] < min_lvl) min_lvl = levels[i*PW +: PW];
            if (levels[i*PW +: PW] == '0) any_empty = 1'b1;
            else                          all_empty = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= RD_WAIT_FILL;
            unf   <= 1'b0;
        end else begin
            state <= nxt;
            if (unf_set) unf <= 1'b1;
        end
    end

    always_comb begin
        nxt     = state;
        pop     = 1'b0;
        unf_set = 1'b0;
        unique case (state)
            RD_WAIT_FILL: begin
                if (min_lvl >= HALF_LVL) nxt = RD_STREAM;      // START
            end
            RD_STREAM: begin
                if (!any_empty) begin
                    pop = 1'b1;
                end else begin
                    nxt     = RD_WAIT_FILL;                    // FINISH
                    unf_set = !all_empty;
                end
            end
            default: nxt = RD_WAIT_FILL;
        endcase
    end

    assert_start_half_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == RD_WAIT_FILL && state == RD_STREAM) |-> ($past(min_lvl) >= HALF_LVL));

    assert_unf_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        unf |=> unf);

    assert_unf_in_burst_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unf) |-> ($past(state) == RD_STREAM));
endmodule

// File: rtl/deskew_line_buffer.sv
`timescale 1ns/1ps
module deskew_line_buffer #(
    parameter int NCH   = 4,
    parameter int DW    = 16,
    parameter int DEPTH = 512
) (
    input  logic              sys_clk,
    input  logic              rst_n,
    input  logic [NCH-1:0]    lane_clk,
    input  logic [NCH-1:0]    lane_valid,
    input  logic [NCH*DW-1:0] lane_data,
    output logic [NCH*DW-1:0] word_data,
    output logic              word_valid,
    output logic              overflow,
    output logic              underflow
);
    localparam int PW   = $clog2(DEPTH) + 1;
    localparam int HALF = DEPTH / 2;

    logic [NCH*PW-1:0] levels;
    logic [NCH*DW-1:0] head_data;
    logic [NCH-1:0]    ovf_vec;
    logic              pop;

    for (genvar i = 0; i < NCH; i++) begin : g_lane
        dlb_lane_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
            .wr_clk  (lane_clk[i]),
            .rst_n   (rst_n),
            .wr_en   (lane_valid[i]),
            .wr_data (lane_data[i*DW +: DW]),
            .rd_clk  (sys_clk),
            .rd_pop  (pop),
            .rd_data (head_data[i*DW +: DW]),
            .rd_level(levels[i*PW +: PW]),
            .ovf_rd  (ovf_vec[i])
        );
    end

    dlb_read_ctrl #(.NCH(NCH), .PW(PW), .HALF(HALF)) u_ctrl (
        .clk   (sys_clk),
        .rst_n (rst_n),
        .levels(levels),
        .pop   (pop),
        .unf   (underflow)
    );

    always_ff @(posedge sys_clk or negedge rst_n) begin
        if (!rst_n) begin
            word_valid <= 1'b0;
            word_data  <= '0;
        end else begin
            word_valid <= pop;
            if (pop) word_data <= head_data;
        end
    end

    assign overflow = |ovf_vec;

    assert_overflow_sticky_R5: assert property (@(posedge sys_clk) disable iff (!rst_n)
        overflow |=> overflow);
endmodule

// File: tb/sim_deskew_line_buffer.sv
`timescale 1ns/1ps
module sim_deskew_line_buffer;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic s0 = 1'b0, s1 = 1'b0, s2 = 1'b0, s3 = 1'b0;
    logic [3:0]  lv = '0;
    logic [63:0] ld = '0;
    logic [63:0] word_data;
    logic        word_valid, overflow, underflow;

    always #4    clk = ~clk;   // 125 MHz
    always #3.5  s0 = ~s0;
    always #3.7  s1 = ~s1;
    always #3.3  s2 = ~s2;
    always #3.9  s3 = ~s3;

    deskew_line_buffer u0 (
        .sys_clk   (clk),
        .rst_n     (rst_n),
        .lane_clk  ({s3, s2, s1, s0}),
        .lane_valid(lv),
        .lane_data (ld),
        .word_data (word_data),
        .word_valid(word_valid),
        .overflow  (overflow),
        .underflow (underflow)
    );

    int checks = 0;
    int errors = 0;
    int rx_cnt = 0;
    logic [63:0] exp_q[$];

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] pat(input int line, input int lane, input int k);
        logic [3:0] l4 = line[3:0];
        logic [1:0] n2 = lane[1:0];
        logic [9:0] k10 = k[9:0];
        return {l4, n2, k10};
    endfunction

    task automatic wait_strobe(input int lane);
        case (lane)
            0: @(negedge s0);
            1: @(negedge s1);
            2: @(negedge s2);
            default: @(negedge s3);
        endcase
    endtask

    task automatic drive_lane(input int lane, input int line, input int first, input int n, input int gap_every);
        for (int k = 0; k < n; k++) begin
            wait_strobe(lane);
            lv[lane] = 1'b1;
            ld[lane*16 +: 16] = pat(line, lane, first + k);
            if (gap_every > 0 && (k % gap_every) == gap_every - 1) begin
                wait_strobe(lane);
                lv[lane] = 1'b0;
                ld[lane*16 +: 16] = 16'hDEAD;   // R8: junk on an idle edge
            end
        end
        wait_strobe(lane);
        lv[lane] = 1'b0;
    endtask

    task automatic expect_words(input int line, input int first, input int n);
        for (int k = 0; k < n; k++)
            exp_q.push_back({pat(line, 3, first + k), pat(line, 2, first + k),
                             pat(line, 1, first + k), pat(line, 0, first + k)});
    endtask

    task automatic drain(input string req);
        for (int c = 0; c < 20000 && exp_q.size() != 0; c++) @(negedge clk);
        repeat (50) @(negedge clk);
        check(exp_q.size() == 0, req, 64'(exp_q.size()), 64'd0);
        check(word_valid == 1'b0, req, 64'(word_valid), 64'd0);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        lv = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && word_valid) begin
            rx_cnt++;
            if (exp_q.size() == 0) begin
                check(1'b0, "R4 unexpected word", word_data, 64'd0);
            end else begin
                logic [63:0] e;
                e = exp_q.pop_front();
                check(word_data == e, "R3 merged word", word_data, e);
            end
        end
    end

    initial begin
        #1000000;
        errors++;
        $display("FAIL R4 watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int rx0;
        do_reset();
        // R1 reset state
        check(word_valid == 1'b0, "R1 word_valid", 64'(word_valid), 64'd0);
        check(overflow == 1'b0, "R1 overflow", 64'(overflow), 64'd0);
        check(underflow == 1'b0, "R1 underflow", 64'(underflow), 64'd0);

        // R3/R4/R8/R9: full line, lane 2 with idle strobe edges
        expect_words(1, 0, 512);
        fork
            drive_lane(0, 1, 0, 512, 0);
            drive_lane(1, 1, 0, 512, 0);
            drive_lane(2, 1, 0, 512, 8);
            drive_lane(3, 1, 0, 512, 0);
        join
        drain("R4 full line");
        check(rx_cnt == 512, "R8 word count", 64'(rx_cnt), 64'd512);
        check(overflow == 1'b0, "R9 no overflow", 64'(overflow), 64'd0);
        check(underflow == 1'b0, "R6 clean finish", 64'(underflow), 64'd0);

        // R2: lane 3 held below half fill
        rx0 = rx_cnt;
        expect_words(2, 0, 300);
        fork
            drive_lane(0, 2, 0, 300, 0);
            drive_lane(1, 2, 0, 300, 0);
            drive_lane(2, 2, 0, 300, 0);
            drive_lane(3, 2, 0, 200, 0);
        join
        repeat (300) @(negedge clk);
        check(rx_cnt == rx0, "R2 no early read", 64'(rx_cnt - rx0), 64'd0);
        drive_lane(3, 2, 200, 100, 0);
        drain("R2 read after half");
        check(rx_cnt - rx0 == 300, "R2 word count", 64'(rx_cnt - rx0), 64'd300);

        // R6: lane 0 carries four extra words
        expect_words(3, 0, 300);
        fork
            drive_lane(0, 3, 0, 304, 0);
            drive_lane(1, 3, 0, 300, 0);
            drive_lane(2, 3, 0, 300, 0);
            drive_lane(3, 3, 0, 300, 0);
        join
        drain("R6 misaligned line");
        check(underflow == 1'b1, "R6 underflow set", 64'(underflow), 64'd1);
        check(overflow == 1'b0, "R6 overflow clear", 64'(overflow), 64'd0);
        do_reset();
        check(underflow == 1'b0, "R7 underflow cleared", 64'(underflow), 64'd0);

        // R9 / R5: lane 0 alone to full, then one more
        rx0 = rx_cnt;
        drive_lane(0, 4, 0, 512, 0);
        repeat (20) @(negedge clk);
        check(overflow == 1'b0, "R9 512 words fit", 64'(overflow), 64'd0);
        drive_lane(0, 4, 512, 1, 0);
        repeat (20) @(negedge clk);
        check(overflow == 1'b1, "R5 overflow set", 64'(overflow), 64'd1);
        repeat (50) @(negedge clk);
        check(overflow == 1'b1, "R5 overflow held", 64'(overflow), 64'd1);
        check(rx_cnt == rx0, "R2 single lane no read", 64'(rx_cnt - rx0), 64'd0);
        do_reset();
        check(overflow == 1'b0, "R7 overflow cleared", 64'(overflow), 64'd0);

        // R7 FIFOs emptied: fresh line aligned, gaps on lane 0
        expect_words(5, 0, 400);
        fork
            drive_lane(0, 5, 0, 400, 8);
            drive_lane(1, 5, 0, 400, 0);
            drive_lane(2, 5, 0, 400, 0);
            drive_lane(3, 5, 0, 400, 0);
        join
        drain("R7 line after reset");
        check(underflow == 1'b0, "R7 no stale words", 64'(underflow), 64'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule